// File: doc/BRIEF.md
# Two-Way Data Cache Controller with Way Locking

This block holds the tags, line state and replacement choice of a two-way set-associative data cache with 32-byte lines and 8 KB per way. A CPU access presents a virtual index (line index plus doubleword offset) together with the physical tag produced by a translation unit working in parallel. The controller compares both ways, checks the parity bit stored with each tag, and answers with a hit or miss and a 64-bit doubleword with one even-parity bit per byte. The data array is held in plain registers.

On a miss it chooses the way to refill. A free way is taken first, otherwise the way used least recently. Each way has a lock input: a locked way keeps its lines and is never chosen for refill. With both ways locked, the access bypasses the cache. Stores run write-back or write-through, with or without allocation on a miss. External memory is reached through a single request/acknowledge channel. A whole line moves in one acknowledged beat, and a dirty victim is written back before its replacement is fetched.

Top module: `dcache_ctl`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `bus_req_valid` are 0, and every line is invalid, so the first access to any index misses.
- R2: A read hit returns the stored doubleword selected by the two offset bits, with `resp_hit`=1 and `resp_way` naming the matching way, and makes no bus request.
- R3: A read miss issues one request of kind 0 (line fetch) at doubleword address {tag, low 7 index bits, 00}. The line is installed in the lowest-numbered invalid unlocked way, and the response carries the fetched doubleword with `resp_hit`=0.
- R4: With both ways valid and unlocked, a miss replaces the way that was not used most recently at that index.
- R5: A way whose `lock_mask` bit is set is never refilled: a miss goes to the other way, and lines in the locked way keep hitting.
- R6: With both `lock_mask` bits set, a read miss issues kind 3 (single read) at the doubleword address and a write miss issues kind 2. Nothing is installed, so a repeat access misses again.
- R7: In write-back mode a store hit merges the bytes enabled by `req_be` (bit i selects byte i), makes no bus request, and marks the line dirty.
- R8: A dirty victim is first sent as kind 1 (writeback), carrying its own line address and the full line, and only then is the kind 0 fetch of the new line issued.
- R9: In write-through mode a store hit updates the array and issues kind 2 with the doubleword address, the store data in the low 64 bits, and the byte enables.
- R10: A store miss without write-allocate issues only kind 2 and installs nothing.
- R11: A store miss with write-allocate fetches the line, merges the store into it, and in write-through mode then issues kind 2.
- R12: A valid tag whose stored parity is wrong is treated as a miss. `tag_err` pulses for one cycle, and the line is refetched into that way.
- R13: `resp_rpar` bit i is the XOR of bits 8i+7..8i of `resp_rdata`.
- R14: A bus request holds its kind and address until `bus_ack`, and each acknowledge completes one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU access present |
| req_ready | output | 1 | Controller idle, access accepted |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vidx | input | 10 | Virtual line index (upper 8) and doubleword offset (lower 2) |
| req_ptag | input | 24 | Physical tag from translation |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| lock_mask | input | 2 | Per-way lock, bit w locks way w |
| wback_mode | input | 1 | 1 = write-back, 0 = write-through |
| wr_alloc | input | 1 | Allocate on store miss |
| tag_par_inject | input | 1 | Flip stored tag parity on the install in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Access hit the cache |
| resp_way | output | 1 | Way that hit or was filled |
| resp_rdata | output | 64 | Load data |
| resp_rpar | output | 8 | Per-byte parity of load data |
| tag_err | output | 1 | Tag parity error pulse |
| bus_req_valid | output | 1 | Memory request pending |
| bus_req_kind | output | 2 | 0 fetch, 1 writeback, 2 write, 3 read |
| bus_req_addr | output | 33 | Doubleword address |
| bus_req_wdata | output | 256 | Writeback line or store data |
| bus_req_be | output | 8 | Byte enables for kind 2 |
| bus_ack | input | 1 | Request completed |
| bus_rdata | input | 256 | Line returned with the acknowledge |

## Verification
Several tags are driven onto one index so that the invalid-first choice, the recency choice and the locked-way exclusion each produce a different `resp_way` or a different follow-up hit or miss. Stores run under each combination of write policy and allocation. The sequence and contents of the bus log then show a silent merge, a write-through, a write-around, fetch-then-write, or writeback-then-fetch. A line installed with a corrupted tag parity shows that a matching but damaged tag gives a miss and a refetch instead of a hit. Uncached traffic with both ways locked shows that nothing is installed.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int DW  = 64;
    localparam int BPW = DW / 8;

    typedef enum logic [1:0] {
        BK_FILL  = 2'd0,
        BK_WBACK = 2'd1,
        BK_WRITE = 2'd2,
        BK_READ  = 2'd3
    } bus_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOOK  = 3'd1,
        ST_WBACK = 3'd2,
        ST_FILL  = 3'd3,
        ST_WRITE = 3'd4,
        ST_READ  = 3'd5
    } ctl_state_e;

    function automatic logic [BPW-1:0] byte_parity(input logic [DW-1:0] d);
        logic [BPW-1:0] p;
        for (int i = 0; i < BPW; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_d,
                                                  input logic [DW-1:0] new_d,
                                                  input logic [BPW-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < BPW; i++) m[i*8 +: 8] = be[i] ? new_d[i*8 +: 8] : old_d[i*8 +: 8];
        return m;
    endfunction

endpackage

// File: rtl/dc_tags.sv
module dc_tags #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      lk_idx,
    input  logic [TAG_W-1:0]      lk_tag,
    output logic [1:0]            hit_vec,
    output logic [1:0]            perr_vec,
    output logic [1:0]            valid_vec,
    output logic [1:0]            dirty_vec,
    output logic [1:0][TAG_W-1:0] way_tag,
    output logic                  lru_way,
    input  logic                  ins_en,
    input  logic                  ins_way,
    input  logic [TAG_W-1:0]      ins_tag,
    input  logic                  ins_dirty,
    input  logic                  ins_flip,
    input  logic                  dset_en,
    input  logic                  dset_way,
    input  logic                  touch_en,
    input  logic                  touch_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W:0]  tag_mem [SETS];
        logic [SETS-1:0] vld_q;
        logic [SETS-1:0] drt_q;
        logic [TAG_W:0]  entry;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
                drt_q <= '0;
            end else if (ins_en && ins_way == 1'(w)) begin
                vld_q[lk_idx] <= 1'b1;
                drt_q[lk_idx] <= ins_dirty;
            end else if (dset_en && dset_way == 1'(w)) begin
                drt_q[lk_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (ins_en && ins_way == 1'(w))
                tag_mem[lk_idx] <= {(^ins_tag) ^ ins_flip, ins_tag};
        end

        assign entry        = tag_mem[lk_idx];
        assign valid_vec[w] = vld_q[lk_idx];
        assign perr_vec[w]  = vld_q[lk_idx] & (^entry);
        assign hit_vec[w]   = vld_q[lk_idx] & ~(^entry) & (entry[TAG_W-1:0] == lk_tag);
        assign dirty_vec[w] = drt_q[lk_idx];
        assign way_tag[w]   = entry[TAG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)           lru_q <= '0;
        else if (touch_en) lru_q[lk_idx] <= ~touch_way;
    end

    assign lru_way = lru_q[lk_idx];

endmodule

// File: rtl/dc_victim.sv
module dc_victim (
    input  logic [1:0] lock_mask,
    input  logic [1:0] usable,
    input  logic       lru_way,
    output logic       vic_way,
    output logic       vic_none
);
    always_comb begin
        vic_none = &lock_mask;
        if (lock_mask[0])      vic_way = 1'b1;
        else if (lock_mask[1]) vic_way = 1'b0;
        else if (!usable[0])   vic_way = 1'b0;
        else if (!usable[1])   vic_way = 1'b1;
        else                   vic_way = lru_way;
    end
endmodule

// File: rtl/dc_data.sv
module dc_data
    import dc_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int WORDS = 4,
    localparam int OFF_W     = $clog2(WORDS),
    localparam int LINE_BITS = DW * WORDS
) (
    input  logic                   clk,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   rd_way,
    output logic [LINE_BITS-1:0]   rd_line,
    output logic [BPW*WORDS-1:0]   rd_lpar,
    input  logic                   fill_en,
    input  logic                   fill_way,
    input  logic [LINE_BITS-1:0]   fill_line,
    input  logic                   wr_en,
    input  logic                   wr_way,
    input  logic [OFF_W-1:0]       wr_off,
    input  logic [DW-1:0]          wr_data,
    input  logic [BPW-1:0]         wr_be
);
    localparam int SETS = 1 << IDX_W;

    logic [LINE_BITS-1:0] way_line [2];
    logic [BPW*WORDS-1:0] way_par  [2];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [DW+BPW-1:0] arr [SETS*WORDS];
        logic [DW-1:0]     merged;

        assign merged = merge_bytes(arr[{idx, wr_off}][DW-1:0], wr_data, wr_be);

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(w)) begin
                for (int k = 0; k < WORDS; k++)
                    arr[{idx, OFF_W'(k)}] <= {byte_parity(fill_line[k*DW +: DW]), fill_line[k*DW +: DW]};
            end else if (wr_en && wr_way == 1'(w)) begin
                arr[{idx, wr_off}] <= {byte_parity(merged), merged};
            end
        end

        for (genvar k = 0; k < WORDS; k++) begin : g_word
            assign way_line[w][k*DW +: DW]   = arr[{idx, OFF_W'(k)}][DW-1:0];
            assign way_par[w][k*BPW +: BPW]  = arr[{idx, OFF_W'(k)}][DW+BPW-1:DW];
        end
    end

    assign rd_line = way_line[rd_way];
    assign rd_lpar = way_par[rd_way];

endmodule

// File: rtl/dcache_ctl.sv
module dcache_ctl
    import dc_pkg::*;
#(
    parameter int PA_W       = 36,
    parameter int WAY_BYTES  = 8192,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 4096,
    localparam int WORDS     = LINE_BYTES / 8,
    localparam int OFF_W     = $clog2(WORDS),
    localparam int IDX_W     = $clog2(WAY_BYTES / LINE_BYTES),
    localparam int PIDX_W    = $clog2(PAGE_BYTES / LINE_BYTES),
    localparam int TAG_W     = PA_W - $clog2(PAGE_BYTES),
    localparam int BA_W      = PA_W - 3,
    localparam int LINE_BITS = DW * WORDS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [IDX_W+OFF_W-1:0] req_vidx,
    input  logic [TAG_W-1:0]       req_ptag,
    input  logic [DW-1:0]          req_wdata,
    input  logic [BPW-1:0]         req_be,
    input  logic [1:0]             lock_mask,
    input  logic                   wback_mode,
    input  logic                   wr_alloc,
    input  logic                   tag_par_inject,
    output logic                   resp_valid,
    output logic                   resp_hit,
    output logic                   resp_way,
    output logic [DW-1:0]          resp_rdata,
    output logic [BPW-1:0]         resp_rpar,
    output logic                   tag_err,
    output logic                   bus_req_valid,
    output logic [1:0]             bus_req_kind,
    output logic [BA_W-1:0]        bus_req_addr,
    output logic [LINE_BITS-1:0]   bus_req_wdata,
    output logic [BPW-1:0]         bus_req_be,
    input  logic                   bus_ack,
    input  logic [LINE_BITS-1:0]   bus_rdata
);
    typedef struct packed {
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
        logic [TAG_W-1:0] tag;
        logic [DW-1:0]    wd;
        logic [BPW-1:0]   be;
    } acc_t;

    ctl_state_e st;
    acc_t       q;
    logic       vic_q, hit_q, way_q;

    logic [1:0]            hit_vec, perr_vec, valid_vec, dirty_vec, usable;
    logic [1:0][TAG_W-1:0] way_tag;
    logic                  lru_way, vic_way, vic_none, hit_any, hit_way;
    logic                  ins_en, dset_en, touch_en, touch_way, wr_en, rd_way;
    logic [LINE_BITS-1:0]  rd_line, fill_line;
    logic [BPW*WORDS-1:0]  rd_lpar;
    logic [DW-1:0]         cur_dw, bus_dw;
    logic [BPW-1:0]        cur_par;
    bus_kind_e             kind;

    assign hit_any = |hit_vec;
    assign hit_way = hit_vec[1];
    assign usable  = valid_vec & ~perr_vec;
    assign cur_dw  = rd_line[int'(q.off)*DW +: DW];
    assign cur_par = rd_lpar[int'(q.off)*BPW +: BPW];
    assign bus_dw  = bus_rdata[int'(q.off)*DW +: DW];

    // Update strobes into the tag and data stores.
    assign ins_en    = (st == ST_FILL) && bus_ack;
    assign dset_en   = (st == ST_LOOK) && hit_any && q.wr && wback_mode;
    assign wr_en     = (st == ST_LOOK) && hit_any && q.wr;
    assign touch_en  = ((st == ST_LOOK) && hit_any) || ins_en;
    assign touch_way = (st == ST_FILL) ? vic_q : hit_way;
    assign rd_way    = (st == ST_WBACK) ? vic_q : hit_way;

    always_comb begin
        fill_line = bus_rdata;
        if (q.wr) fill_line[int'(q.off)*DW +: DW] = merge_bytes(bus_dw, q.wd, q.be);
    end

    dc_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk, .rst,
        .lk_idx(q.idx), .lk_tag(q.tag),
        .hit_vec, .perr_vec, .valid_vec, .dirty_vec, .way_tag, .lru_way,
        .ins_en, .ins_way(vic_q), .ins_tag(q.tag),
        .ins_dirty(q.wr && wback_mode), .ins_flip(tag_par_inject),
        .dset_en, .dset_way(hit_way),
        .touch_en, .touch_way
    );

    dc_victim u_victim (
        .lock_mask, .usable, .lru_way, .vic_way, .vic_none
    );

    dc_data #(.IDX_W(IDX_W), .WORDS(WORDS)) u_data (
        .clk, .idx(q.idx), .rd_way, .rd_line, .rd_lpar,
        .fill_en(ins_en), .fill_way(vic_q), .fill_line,
        .wr_en, .wr_way(hit_way), .wr_off(q.off), .wr_data(q.wd), .wr_be(q.be)
    );

    // Bus request decode from state.
    always_comb begin
        kind          = BK_FILL;
        bus_req_addr  = {q.tag, q.idx[PIDX_W-1:0], q.off};
        bus_req_wdata = LINE_BITS'(q.wd);
        bus_req_be    = q.be;
        unique case (st)
            ST_WBACK: begin
                kind          = BK_WBACK;
                bus_req_addr  = {way_tag[vic_q], q.idx[PIDX_W-1:0], {OFF_W{1'b0}}};
                bus_req_wdata = rd_line;
                bus_req_be    = '1;
            end
            ST_FILL: begin
                bus_req_addr = {q.tag, q.idx[PIDX_W-1:0], {OFF_W{1'b0}}};
                bus_req_be   = '1;
            end
            ST_WRITE: kind = BK_WRITE;
            ST_READ:  kind = BK_READ;
            default:  kind = BK_FILL;
        endcase
    end

    assign bus_req_valid = (st == ST_WBACK) || (st == ST_FILL) || (st == ST_WRITE) || (st == ST_READ);
    assign bus_req_kind  = kind;
    assign req_ready     = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            q          <= '0;
            vic_q      <= 1'b0;
            hit_q      <= 1'b0;
            way_q      <= 1'b0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_way   <= 1'b0;
            resp_rdata <= '0;
            resp_rpar  <= '0;
            tag_err    <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            tag_err    <= 1'b0;
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    q  <= '{wr: req_write, idx: req_vidx[IDX_W+OFF_W-1:OFF_W],
                            off: req_vidx[OFF_W-1:0], tag: req_ptag, wd: req_wdata, be: req_be};
                    st <= ST_LOOK;
                end
                ST_LOOK: begin
                    tag_err <= |perr_vec;
                    hit_q   <= hit_any;
                    way_q   <= hit_any ? hit_way : 1'b0;
                    if (hit_any) begin
                        if (q.wr && !wback_mode) st <= ST_WRITE;
                        else begin
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b1;
                            resp_way   <= hit_way;
                            resp_rdata <= q.wr ? '0 : cur_dw;
                            resp_rpar  <= q.wr ? '0 : cur_par;
                            st         <= ST_IDLE;
                        end
                    end else if (q.wr && (!wr_alloc || vic_none)) begin
                        st <= ST_WRITE;
                    end else if (vic_none) begin
                        st <= ST_READ;
                    end else begin
                        vic_q <= vic_way;
                        st    <= (usable[vic_way] && dirty_vec[vic_way]) ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: if (bus_ack) st <= ST_FILL;
                ST_FILL: if (bus_ack) begin
                    way_q <= vic_q;
                    if (q.wr && !wback_mode) st <= ST_WRITE;
                    else begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_way   <= vic_q;
                        resp_rdata <= q.wr ? '0 : bus_dw;
                        resp_rpar  <= q.wr ? '0 : byte_parity(bus_dw);
                        st         <= ST_IDLE;
                    end
                end
                ST_WRITE: if (bus_ack) begin
                    resp_valid <= 1'b1;
                    resp_hit   <= hit_q;
                    resp_way   <= way_q;
                    resp_rdata <= '0;
                    resp_rpar  <= '0;
                    st         <= ST_IDLE;
                end
                ST_READ: if (bus_ack) begin
                    resp_valid <= 1'b1;
                    resp_hit   <= 1'b0;
                    resp_way   <= 1'b0;
                    resp_rdata <= bus_dw;
                    resp_rpar  <= byte_parity(bus_dw);
                    st         <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dcache_chk.sv
module dcache_chk
    import dc_pkg::*;
#(
    parameter int BA_W = 33
) (
    input logic            clk,
    input logic            rst,
    input logic            req_ready,
    input logic            resp_valid,
    input logic            bus_req_valid,
    input logic [1:0]      bus_req_kind,
    input logic [BA_W-1:0] bus_req_addr,
    input logic            bus_ack,
    input logic [1:0]      lock_mask,
    input logic            fill_en,
    input logic            fill_way
);
    // R14: a pending request keeps its kind and address until acknowledged
    assert_req_hold_R14: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid && !bus_ack |=> bus_req_valid && $stable(bus_req_kind) && $stable(bus_req_addr));

    // R5: an install never lands in a locked way
    assert_locked_skip_R5: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !lock_mask[fill_way]);

    // R8: a completed writeback is followed at once by the line fetch
    assert_wb_first_R8: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid && bus_ack && bus_req_kind == 2'(BK_WBACK) |=> bus_req_valid && bus_req_kind == 2'(BK_FILL));

    // R6: uncached reads only when both ways are locked
    assert_uncached_R6: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid && bus_req_kind == 2'(BK_READ) |-> lock_mask == 2'b11);

    // R2: a response is a single-cycle strobe issued as the controller goes idle
    assert_resp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> req_ready ##1 !resp_valid);

    // R1: no bus traffic while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_req_valid);
endmodule

bind dcache_ctl dcache_chk #(.BA_W(BA_W)) i_chk (
    .clk, .rst, .req_ready, .resp_valid, .bus_req_valid, .bus_req_kind,
    .bus_req_addr, .bus_ack, .lock_mask, .fill_en(ins_en), .fill_way(vic_q)
);

// File: tb/test_dcache_ctl.sv
module test_dcache_ctl;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 0, req_ready, req_write = 0;
    logic [9:0]   req_vidx = '0;
    logic [23:0]  req_ptag = '0;
    logic [63:0]  req_wdata = '0;
    logic [7:0]   req_be = '0;
    logic [1:0]   lock_mask = 2'b00;
    logic         wback_mode = 0, wr_alloc = 0, tag_par_inject = 0;
    logic         resp_valid, resp_hit, resp_way, tag_err;
    logic [63:0]  resp_rdata;
    logic [7:0]   resp_rpar;
    logic         bus_req_valid;
    logic [1:0]   bus_req_kind;
    logic [32:0]  bus_req_addr;
    logic [255:0] bus_req_wdata;
    logic [7:0]   bus_req_be;
    logic         bus_ack = 0;
    logic [255:0] bus_rdata = '0;

    int checks = 0, errors = 0;
    int nlog = 0;
    logic [1:0]   log_kind  [64];
    logic [32:0]  log_addr  [64];
    logic [255:0] log_wdata [64];
    logic [7:0]   log_be    [64];
    logic         r_hit, r_way, r_terr;
    logic [63:0]  r_data;
    logic [7:0]   r_par;

    dcache_ctl i_dcache_ctl (.*);

    always #4 clk = ~clk;

    function automatic logic [255:0] line_of(logic [30:0] la);
        logic [255:0] l;
        for (int k = 0; k < 4; k++) l[k*64 +: 64] = {1'b0, la, 32'hC0DE0000 + 32'(k)};
        return l;
    endfunction

    function automatic logic [63:0] exp_dw(logic [23:0] tag, logic [7:0] idx, int off);
        return {1'b0, tag, idx[6:0], 32'hC0DE0000 + 32'(off)};
    endfunction

    function automatic logic [32:0] daddr(logic [23:0] tag, logic [7:0] idx, logic [1:0] off);
        return {tag, idx[6:0], off};
    endfunction

    function automatic logic [7:0] par_of(logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = d[i*8] ^ d[i*8+1] ^ d[i*8+2] ^ d[i*8+3]
                                         ^ d[i*8+4] ^ d[i*8+5] ^ d[i*8+6] ^ d[i*8+7];
        return p;
    endfunction

    // Memory model: one acknowledge per request, whole line returned.
    always @(negedge clk) begin
        if (rst) bus_ack = 1'b0;
        else if (bus_ack) bus_ack = 1'b0;
        else if (bus_req_valid) begin
            if (nlog < 64) begin
                log_kind[nlog]  = bus_req_kind;
                log_addr[nlog]  = bus_req_addr;
                log_wdata[nlog] = bus_req_wdata;
                log_be[nlog]    = bus_req_be;
            end
            nlog++;
            bus_rdata = line_of(bus_req_addr[32:2]);
            bus_ack   = 1'b1;
        end
    end

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic access(bit wr, logic [7:0] idx, logic [1:0] off, logic [23:0] tag,
                          logic [63:0] wd, logic [7:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_vidx = {idx, off}; req_ptag = tag;
        req_wdata = wd; req_be = be;
        @(negedge clk);
        req_valid = 0;
        r_terr = 0;
        for (int n = 0; n < 60; n++) begin
            if (tag_err) r_terr = 1;
            if (resp_valid) begin
                r_hit = resp_hit; r_way = resp_way; r_data = resp_rdata; r_par = resp_rpar;
                return;
            end
            @(negedge clk);
        end
        errors++;
        $display("FAIL R14 no response actual=0 expected=1");
    endtask

    task automatic rd(logic [7:0] idx, logic [1:0] off, logic [23:0] tag);
        access(0, idx, off, tag, '0, '0);
    endtask

    task automatic t_reset();
        chk("R1 req_ready", 64'(req_ready), 1);
        chk("R1 resp_valid", 64'(resp_valid), 0);
        chk("R1 bus_req_valid", 64'(bus_req_valid), 0);
    endtask

    task automatic t_read_fill();
        nlog = 0;
        rd(8'd3, 2'd2, 24'h000011);
        chk("R1 first access misses", 64'(r_hit), 0);
        chk("R3 fill count", 64'(nlog), 1);
        chk("R3 fill kind", 64'(log_kind[0]), 0);
        chk("R3 fill addr", 64'(log_addr[0]), 64'(daddr(24'h11, 8'd3, 2'd0)));
        chk("R3 miss data", r_data, exp_dw(24'h11, 8'd3, 2));
        chk("R3 install way", 64'(r_way), 0);
        chk("R13 miss parity", 64'(r_par), 64'(par_of(r_data)));
        nlog = 0;
        rd(8'd3, 2'd1, 24'h000011);
        chk("R2 hit", 64'(r_hit), 1);
        chk("R2 hit data", r_data, exp_dw(24'h11, 8'd3, 1));
        chk("R2 no bus", 64'(nlog), 0);
        chk("R13 hit parity", 64'(r_par), 64'(par_of(r_data)));
    endtask

    task automatic t_lru();
        rd(8'd4, 0, 24'hA1);
        rd(8'd4, 0, 24'hA2);
        chk("R3 second way", 64'(r_way), 1);
        rd(8'd4, 0, 24'hA1);
        chk("R2 hit way0", 64'(r_way), 0);
        rd(8'd4, 0, 24'hA3);
        chk("R4 replace older way", 64'(r_way), 1);
        rd(8'd4, 0, 24'hA1);
        chk("R4 recent line kept", 64'(r_hit), 1);
        rd(8'd4, 0, 24'hA2);
        chk("R4 older line evicted", 64'(r_hit), 0);
    endtask

    task automatic t_lock();
        rd(8'd6, 0, 24'hB1);
        rd(8'd6, 0, 24'hB2);
        rd(8'd6, 0, 24'hB2);
        lock_mask = 2'b01;
        rd(8'd6, 0, 24'hB3);
        chk("R5 refill avoids locked way", 64'(r_way), 1);
        rd(8'd6, 1, 24'hB1);
        chk("R5 locked line hits", 64'(r_hit), 1);
        chk("R5 locked line way", 64'(r_way), 0);
        lock_mask = 2'b00;
    endtask

    task automatic t_both_locked();
        lock_mask = 2'b11;
        nlog = 0;
        rd(8'd7, 1, 24'h71);
        chk("R6 uncached kind", 64'(log_kind[0]), 3);
        chk("R6 uncached addr", 64'(log_addr[0]), 64'(daddr(24'h71, 8'd7, 2'd1)));
        chk("R6 uncached data", r_data, exp_dw(24'h71, 8'd7, 1));
        rd(8'd7, 1, 24'h71);
        chk("R6 not installed", 64'(r_hit), 0);
        chk("R6 second uncached read", 64'(nlog), 2);
        access(1, 8'd7, 0, 24'h71, 64'h5, 8'hFF);
        chk("R6 uncached write kind", 64'(log_kind[2]), 2);
        lock_mask = 2'b00;
    endtask

    task automatic t_wback();
        logic [63:0] merged;
        wback_mode = 1; wr_alloc = 1;
        rd(8'd8, 0, 24'h81);
        nlog = 0;
        access(1, 8'd8, 1, 24'h81, 64'h11112222_33334444, 8'h0F);
        chk("R7 store hit", 64'(r_hit), 1);
        chk("R7 no bus traffic", 64'(nlog), 0);
        merged = {exp_dw(24'h81, 8'd8, 1)[63:32], 32'h33334444};
        rd(8'd8, 1, 24'h81);
        chk("R7 merged bytes", r_data, merged);
        rd(8'd8, 0, 24'h82);
        nlog = 0;
        rd(8'd8, 2, 24'h83);
        chk("R8 two requests", 64'(nlog), 2);
        chk("R8 writeback first", 64'(log_kind[0]), 1);
        chk("R8 writeback addr", 64'(log_addr[0]), 64'(daddr(24'h81, 8'd8, 2'd0)));
        chk("R8 writeback data", log_wdata[0][127:64], merged);
        chk("R8 fetch second", 64'(log_kind[1]), 0);
        chk("R8 new line data", r_data, exp_dw(24'h83, 8'd8, 2));
        wback_mode = 0;
    endtask

    task automatic t_wthru();
        wback_mode = 0;
        rd(8'd9, 3, 24'h91);
        nlog = 0;
        access(1, 8'd9, 3, 24'h91, 64'hDEADBEEF_0BADF00D, 8'hFF);
        chk("R9 hit", 64'(r_hit), 1);
        chk("R9 one write", 64'(nlog), 1);
        chk("R9 kind", 64'(log_kind[0]), 2);
        chk("R9 addr", 64'(log_addr[0]), 64'(daddr(24'h91, 8'd9, 2'd3)));
        chk("R9 data", log_wdata[0][63:0], 64'hDEADBEEF_0BADF00D);
        chk("R9 be", 64'(log_be[0]), 64'hFF);
        rd(8'd9, 3, 24'h91);
        chk("R9 array updated", r_data, 64'hDEADBEEF_0BADF00D);
    endtask

    task automatic t_noalloc();
        wback_mode = 0; wr_alloc = 0;
        nlog = 0;
        access(1, 8'd10, 0, 24'hA5, 64'h1, 8'hFF);
        chk("R10 miss", 64'(r_hit), 0);
        chk("R10 only write", 64'(nlog), 1);
        chk("R10 kind", 64'(log_kind[0]), 2);
        nlog = 0;
        rd(8'd10, 0, 24'hA5);
        chk("R10 nothing installed", 64'(r_hit), 0);
        chk("R10 fetch follows", 64'(log_kind[0]), 0);
    endtask

    task automatic t_alloc();
        wback_mode = 0; wr_alloc = 1;
        nlog = 0;
        access(1, 8'd11, 0, 24'hB7, 64'hAAAABBBB_CCCCDDDD, 8'hF0);
        chk("R11 two requests", 64'(nlog), 2);
        chk("R11 fetch first", 64'(log_kind[0]), 0);
        chk("R11 write second", 64'(log_kind[1]), 2);
        rd(8'd11, 0, 24'hB7);
        chk("R11 hit after allocate", 64'(r_hit), 1);
        chk("R11 merged", r_data, {32'hAAAABBBB, exp_dw(24'hB7, 8'd11, 0)[31:0]});
        wr_alloc = 0;
    endtask

    task automatic t_tagerr();
        tag_par_inject = 1;
        rd(8'd12, 0, 24'hC1);
        tag_par_inject = 0;
        nlog = 0;
        rd(8'd12, 0, 24'hC1);
        chk("R12 forced miss", 64'(r_hit), 0);
        chk("R12 error flag", 64'(r_terr), 1);
        chk("R12 refetch", 64'(nlog), 1);
        chk("R12 same way", 64'(r_way), 0);
        rd(8'd12, 0, 24'hC1);
        chk("R12 clean after refill", 64'(r_hit), 1);
        chk("R12 no flag", 64'(r_terr), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_read_fill();
        t_lru();
        t_lock();
        t_both_locked();
        t_wback();
        t_wthru();
        t_noalloc();
        t_alloc();
        t_tagerr();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule